// File: doc/BRIEF.md
# Link-Status Configuration Word Exchanger

This block sits on the PHY side of a serial gigabit MAC link. It reports the current link state, duplex mode and port speed to the MAC. It does this by sending a fixed 16-bit configuration word instead of an ability advertisement. While the status is stable, the transmitter stays in data mode. When any status field changes, the block does three things:

- it raises a configuration-mode flag, so the transmitter sends the word instead of frame data;
- it sends the updated word;
- it waits for the partner's acknowledge and for a shortened link timer, then returns to data mode.

The partner's received word comes with a valid flag and no ready signal. The block takes every word it is offered and never applies back-pressure, so the valid flag qualifies a single cycle only. The link, duplex and speed pins are plain level inputs and are sampled on every clock. The link timer length is a parameter given in clock cycles. The default of 200000 cycles gives 1.6 ms at 125 MHz. One full update then takes two timer periods plus the time the partner needs to acknowledge.

Top module: `lsx_top`

## Requirements
- R1: After reset the configuration-mode flag is 0 and the transmit word is 16'h0001, which means link down, half duplex and 10 Mbps.
- R2: The transmit word carries link (1 = up) in bit 15 and duplex (1 = full) in bit 12. Bit 0 is always 1. Bits 14, 13 and 9:1 are always 0.
- R3: Bits 11:10 carry the speed: 2'b10 = 1000 Mbps, 2'b01 = 100 Mbps, 2'b00 = 10 Mbps. When the speed input shows the reserved code 2'b11, the last valid speed is kept, so 2'b11 never appears in the word.
- R4: When the link, duplex or effective speed differs from the value being reported, then in the next cycle the flag is 1 and the word shows the new status.
- R5: An acknowledge is a received word with bit 14 set while its valid flag is 1. Without one, the block stays in configuration mode indefinitely. Bit 14 while valid is 0 is ignored.
- R6: Configuration mode lasts at least two link-timer periods. If the acknowledge is present from the first cycle, the flag is 1 for exactly 2 × LINK_TMR_CYC cycles. An acknowledge that arrives after the first period has ended gives exactly LINK_TMR_CYC more cycles of configuration mode.
- R7: A status change during an exchange restarts the exchange with the new word. Any acknowledge seen earlier is discarded, and the timing of R6 counts again from the restart.
- R8: In data mode, with no effective status change, the flag stays 0 and the word stays unchanged. This includes a request for the reserved speed code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up_i | input | 1 | Current link state, 1 = up |
| full_dplx_i | input | 1 | Current duplex, 1 = full |
| speed_i | input | 2 | Current speed code (10/01/00, 11 reserved) |
| rx_word_i | input | 16 | Configuration word from the partner |
| rx_word_vld_i | input | 1 | rx_word_i is valid this cycle (always accepted) |
| tx_word_o | output | 16 | Configuration word to transmit |
| cfg_mode_o | output | 1 | 1 = transmitter sends configuration words, 0 = data |

## Verification
The bench builds the block with LINK_TMR_CYC = 8. At that length, the exact durations of R6 can be counted cycle by cycle. Waits of three timer periods can show that the block stays in configuration mode when no acknowledge comes. A restart a few cycles into an exchange falls inside the first timer period. That makes the restart and the discarded acknowledge of R7 visible as a full new 2 × LINK_TMR_CYC window, or as a stall, at the configuration-mode flag.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
  localparam int WORD_W     = 16;
  localparam int BIT_LINK   = 15;
  localparam int BIT_ACK    = 14;
  localparam int BIT_DPLX   = 12;
  localparam int BIT_SPD_LO = 10;

  localparam logic [1:0] SPD_RSVD = 2'b11;

  typedef enum logic [1:0] {
    XS_DATA   = 2'd0,
    XS_SEND   = 2'd1,
    XS_SETTLE = 2'd2
  } xchg_state_e;

  typedef struct packed {
    logic       link;
    logic       fdx;
    logic [1:0] spd;
  } lsx_status_t;

  function automatic logic [WORD_W-1:0] make_word(input lsx_status_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[0]                         = 1'b1;
    w[BIT_LINK]                  = s.link;
    w[BIT_DPLX]                  = s.fdx;
    w[BIT_SPD_LO+1:BIT_SPD_LO]   = s.spd;
    return w;
  endfunction
endpackage

// File: rtl/lsx_status_track.sv
module lsx_status_track
  import lsx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_i,
  input  logic        fdx_i,
  input  logic [1:0]  speed_i,
  output lsx_status_t status_o,
  output logic        chg_o
);
  lsx_status_t st_q;
  lsx_status_t st_now;

  always_comb begin
    st_now.link = link_i;
    st_now.fdx  = fdx_i;
    st_now.spd  = (speed_i == SPD_RSVD) ? st_q.spd : speed_i;
  end

  assign chg_o    = (st_now != st_q);
  assign status_o = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_now;
  end

  // R3: reported speed is never the reserved code
  a_r3_no_rsvd_latched: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.spd != SPD_RSVD);
endmodule

// File: rtl/lsx_link_timer.sv
module lsx_link_timer #(
  parameter int CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R6: timer counts down by one each cycle until it expires
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R6: a fresh start is never already expired
  a_r6_start_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o);
endmodule

// File: rtl/lsx_xchg_fsm.sv
module lsx_xchg_fsm
  import lsx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chg_i,
  input  logic ack_i,
  input  logic tmr_done_i,
  output logic tmr_start_o,
  output logic cfg_mode_o
);
  xchg_state_e st_q, st_d;
  logic        ack_seen_q, ack_seen_d;
  logic        ack_any;

  assign ack_any = ack_seen_q | ack_i;

  always_comb begin
    st_d        = st_q;
    ack_seen_d  = ack_seen_q;
    tmr_start_o = 1'b0;
    if (chg_i) begin
      st_d        = XS_SEND;
      ack_seen_d  = 1'b0;
      tmr_start_o = 1'b1;
    end else begin
      unique case (st_q)
        XS_DATA: ack_seen_d = 1'b0;
        XS_SEND: begin
          if (tmr_done_i && ack_any) begin
            st_d        = XS_SETTLE;
            ack_seen_d  = 1'b0;
            tmr_start_o = 1'b1;
          end else begin
            ack_seen_d = ack_any;
          end
        end
        XS_SETTLE: if (tmr_done_i) st_d = XS_DATA;
        default:   st_d = XS_DATA;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= XS_DATA;
      ack_seen_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      ack_seen_q <= ack_seen_d;
    end
  end

  assign cfg_mode_o = (st_q != XS_DATA);

  // R4: a status change always (re)enters the sending state
  a_r4_chg_to_send: assert property (@(posedge clk) disable iff (!rst_n)
    chg_i |=> (st_q == XS_SEND));
  // R5 and R6: leaving the sending state needs an expired timer and an acknowledge
  a_r5_send_exit_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_SETTLE && $past(st_q) == XS_SEND) |-> $past(tmr_done_i && ack_any));
  // R6: data mode is reached only from the settle period with an expired timer
  a_r6_data_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_DATA && $past(st_q) != XS_DATA) |-> $past(st_q == XS_SETTLE && tmr_done_i));
endmodule

// File: rtl/lsx_top.sv
module lsx_top
  import lsx_pkg::*;
#(
  parameter int LINK_TMR_CYC = 200000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up_i,
  input  logic        full_dplx_i,
  input  logic [1:0]  speed_i,
  input  logic [15:0] rx_word_i,
  input  logic        rx_word_vld_i,
  output logic [15:0] tx_word_o,
  output logic        cfg_mode_o
);
  lsx_status_t status;
  logic        chg;
  logic        ack;
  logic        tmr_start;
  logic        tmr_done;

  lsx_status_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_i   (link_up_i),
    .fdx_i    (full_dplx_i),
    .speed_i  (speed_i),
    .status_o (status),
    .chg_o    (chg)
  );

  assign ack = rx_word_vld_i & rx_word_i[BIT_ACK];

  lsx_xchg_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .chg_i       (chg),
    .ack_i       (ack),
    .tmr_done_i  (tmr_done),
    .tmr_start_o (tmr_start),
    .cfg_mode_o  (cfg_mode_o)
  );

  lsx_link_timer #(.CYC(LINK_TMR_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (tmr_start),
    .done_o  (tmr_done)
  );

  assign tx_word_o = make_word(status);

  // R2: fixed bits of the transmitted word
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word_o[0] && !tx_word_o[14] && !tx_word_o[13] && (tx_word_o[9:1] == '0));
  // R3: a reserved speed request leaves the transmitted speed as it was
  a_r3_hold_speed: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_i == SPD_RSVD) |=> (tx_word_o[11:10] == $past(tx_word_o[11:10])));
endmodule

// File: tb/lsx_top_tb_top.sv
`timescale 1ns/1ps
module lsx_top_tb_top;
  localparam int T = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b0;
  logic        fdx = 1'b0;
  logic [1:0]  spd = 2'b00;
  logic [15:0] rx_word = 16'h0001;
  logic        rx_vld = 1'b0;
  logic [15:0] tx_word;
  logic        cfg_mode;

  int checks = 0;
  int bad = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  lsx_top #(.LINK_TMR_CYC(T)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_up_i     (link_up),
    .full_dplx_i   (fdx),
    .speed_i       (spd),
    .rx_word_i     (rx_word),
    .rx_word_vld_i (rx_vld),
    .tx_word_o     (tx_word),
    .cfg_mode_o    (cfg_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_status(input logic l, input logic f, input logic [1:0] s);
    link_up = l; fdx = f; spd = s;
  endtask

  task automatic cfg_len(output int n);
    n = 0;
    for (int i = 0; i < 10 * T; i++) begin
      @(negedge clk);
      if (cfg_mode) n++;
      else break;
    end
  endtask

  task automatic stay_cfg(input string req, input int cyc);
    int lost;
    lost = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (!cfg_mode) lost++;
    end
    chk(req, lost, 0);
  endtask

  task automatic t_reset;
    chk("R1 cfg", cfg_mode, 0);
    chk("R1 word", tx_word, 16'h0001);
  endtask

  task automatic t_first_change_no_ack;
    int n;
    set_status(1'b1, 1'b1, 2'b10);
    @(negedge clk);
    chk("R4 cfg", cfg_mode, 1);
    chk("R2 word 1000 full up", tx_word, 16'h9801);
    stay_cfg("R5 no ack", 3 * T);
    rx_vld = 1'b1; rx_word = 16'h4001;
    cfg_len(n);
    chk("R6 late ack settle", n, T);
    rx_vld = 1'b0;
  endtask

  task automatic t_ack_without_valid;
    int n;
    rx_vld = 1'b0; rx_word = 16'h4001;
    set_status(1'b1, 1'b0, 2'b01);
    @(negedge clk);
    chk("R3 word 100 half", tx_word, 16'h8401);
    stay_cfg("R5 bit14 not valid", 3 * T);
    rx_vld = 1'b1;
    cfg_len(n);
    chk("R5 valid ack", n, T);
  endtask

  task automatic t_exact_window;
    int n;
    rx_vld = 1'b1; rx_word = 16'h4001;
    set_status(1'b1, 1'b1, 2'b01);
    cfg_len(n);
    chk("R6 two periods", n, 2 * T);
    chk("R2 word", tx_word, 16'h9401);
  endtask

  task automatic t_reserved_idle;
    int hits;
    hits = 0;
    spd = 2'b11;
    for (int i = 0; i < 2 * T; i++) begin
      @(negedge clk);
      if (cfg_mode || tx_word !== 16'h9401) hits++;
    end
    chk("R8 reserved no change", hits, 0);
  endtask

  task automatic t_reserved_with_link_drop;
    int n;
    set_status(1'b0, 1'b1, 2'b11);
    @(negedge clk);
    chk("R3 speed held", tx_word, 16'h1401);
    cfg_len(n);
    chk("R6 window", n, 2 * T - 1);
  endtask

  task automatic t_restart;
    int n;
    rx_vld = 1'b1;
    set_status(1'b0, 1'b1, 2'b10);
    @(negedge clk);
    chk("R4 word", tx_word, 16'h1801);
    @(negedge clk); @(negedge clk);
    link_up = 1'b1;
    cfg_len(n);
    chk("R7 restart window", n, 2 * T);
    chk("R7 restart word", tx_word, 16'h9801);
  endtask

  task automatic t_restart_drops_ack;
    int n;
    rx_vld = 1'b0;
    fdx = 1'b0;
    @(negedge clk);
    chk("R2 word", tx_word, 16'h8801);
    rx_vld = 1'b1;
    @(negedge clk);
    rx_vld = 1'b0;
    @(negedge clk);
    spd = 2'b01;
    @(negedge clk);
    chk("R7 new word", tx_word, 16'h8401);
    stay_cfg("R7 old ack dropped", 3 * T);
    rx_vld = 1'b1;
    cfg_len(n);
    chk("R7 ack after restart", n, T);
    rx_vld = 1'b0;
  endtask

  task automatic t_idle_hold;
    int hits;
    hits = 0;
    for (int i = 0; i < 2 * T; i++) begin
      @(negedge clk);
      if (cfg_mode || tx_word !== 16'h8401) hits++;
    end
    chk("R8 idle hold", hits, 0);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_change_no_ack();
    t_ack_without_valid();
    t_exact_window();
    t_reserved_idle();
    t_reserved_with_link_drop();
    t_restart();
    t_restart_drops_ack();
    t_idle_hold();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end
endmodule